// File: doc/BRIEF.md
# Gap-Coded Tag Command Sequencer

This block drives the downlink from a reader to a 125 kHz rewritable tag. It switches a single carrier-enable output. Each command bit is sent as a burst of carrier whose length carries the bit value, and a fixed carrier-off gap follows every burst. Before any bits, the field is held off for a start gap that puts the tag into command-listening mode.

The block accepts four commands: reset, read block, write block and wake-up. With the command come a page bit, a password-mode flag, a 32-bit password, 32 data bits, an 8-bit block request and a capture length. It serializes the fields in the order the command needs, then ends with a command-specific field-on tail.

- Reset and read leave the field on for a short settling gap. They then assert a capture window for the programmed number of microseconds, after which the field turns off.
- Write holds the field on long enough for the tag to program its memory, then turns it off.
- Wake-up leaves the field on until a stop request.

All timing counts a one-microsecond tick input. Carrier generation and response sampling belong to other blocks.

Top module: `tag_downlink_seq`

## Requirements
- R1: After an accepted start, the field stays off for START_US (400) ticks before the first bit burst.
- R2: A 0 bit is a field-on burst of ZERO_US (144) ticks and a 1 bit is a burst of ONE_US (432) ticks. Every burst, including the last, is followed by a field-off gap of GAP_US (160) ticks.
- R3: Command code 0 (reset) sends the two bits 0,0. The field then comes on for RGAP_US (120) ticks before the capture window.
- R4: Command code 2 (write) sends, in this order: 1, the page bit, the 32-bit password MSB first (only when pwd_en is 1), a 0 lock bit, the 32 data bits MSB first, and blk[2:0] MSB first.
- R5: After the last write gap the field stays on for PROG_US ticks. It then goes off and the command completes.
- R6: Command code 1 (read) sends 1, the page bit, the optional password and a 0 separator. It then sends blk[2:0] MSB first, except when blk is 8'hFF; in that case no block bits are sent.
- R7: Command code 3 (wake-up) sends 1, then 0 whatever the page input, then all 32 password bits. The field stays on and done pulses. Only stop (or a new start) ends the field-on hold.
- R8: For reset and read, after the RGAP_US gap, capture is high for cap_len ticks with the field on. The field then turns off. A cap_len of 0 gives no capture window.
- R9: A start request while busy is ignored; the running frame continues unchanged.
- R10: Done is a single-cycle pulse issued as a command completes, and busy is low in that cycle.
- R11: Out of reset, and whenever no command runs and no wake-up hold is active, field_on, capture and busy are low.
- R12: Sequencing advances only on us_tick; with no tick the outputs and busy hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| start | input | 1 | Begin a command (accepted when not busy) |
| cmd | input | 2 | 0 reset, 1 read, 2 write, 3 wake-up |
| page | input | 1 | Page select bit |
| pwd_en | input | 1 | Send the password (read and write) |
| pwd | input | 32 | Password |
| data | input | 32 | Write data |
| blk | input | 8 | Block request; 8'hFF selects register-read mode |
| cap_len | input | 16 | Capture window length in ticks |
| stop | input | 1 | Ends the wake-up field hold |
| field_on | output | 1 | Carrier enable |
| capture | output | 1 | Response capture window |
| busy | output | 1 | A command is running |
| done | output | 1 | Completion pulse |

## Verification
The bench measures every field-on and field-off run at the pin and decodes the bits from the run lengths. A design that misorders a field, leaves out the lock or separator bit, or drops the gap after the final bit produces a bit list or a gap length that does not match the expected one.

It also aims at the corner cases:
- Register-read mode with password: a design that sent block bits here would decode three extra bits.
- A capture length of zero: a design that did not handle it would show a tail longer than the settling gap.
- A wake-up with page set to 1: the second bit must still be sent as 0.
- A start request mid-frame: a design that accepted it would restart the sequence.
- A stall of the tick: the field and busy must not move while no tick arrives.

// File: rtl/tag_downlink_seq.sv
module tag_downlink_seq #(
  parameter int START_US = 400,
  parameter int ZERO_US  = 144,
  parameter int ONE_US   = 432,
  parameter int GAP_US   = 160,
  parameter int RGAP_US  = 120,
  parameter int PROG_US  = 20000,
  parameter int CNT_W    = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        us_tick,
  input  logic        start,
  input  logic [1:0]  cmd,
  input  logic        page,
  input  logic        pwd_en,
  input  logic [31:0] pwd,
  input  logic [31:0] data,
  input  logic [7:0]  blk,
  input  logic [15:0] cap_len,
  input  logic        stop,
  output logic        field_on,
  output logic        capture,
  output logic        busy,
  output logic        done
);
  localparam int FW   = 70;
  localparam int NB_W = $clog2(FW + 1);
  localparam logic [1:0] C_RST = 2'd0, C_READ = 2'd1, C_WRITE = 2'd2, C_WAKE = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_START, S_ON, S_GAP, S_RGAP, S_CAPT, S_PROG, S_HOLD} st_t;

  st_t              st;
  logic [CNT_W-1:0] cnt;
  logic [FW-1:0]    fr, fr_n;
  logic [NB_W-1:0]  left, nb_n;
  logic [1:0]       kind;
  logic [15:0]      capn;
  logic             hold;

  wire regread = (blk == 8'hFF);

  always_comb begin
    fr_n = '0;
    nb_n = '0;
    case (cmd)
      C_RST: begin
        fr_n = '0;
        nb_n = NB_W'(2);
      end
      C_READ: begin
        if (pwd_en) begin
          fr_n = FW'({1'b1, page, pwd, 1'b0, blk[2:0]}) << (FW - 38);
          nb_n = regread ? NB_W'(35) : NB_W'(38);
        end else begin
          fr_n = FW'({1'b1, page, 1'b0, blk[2:0]}) << (FW - 6);
          nb_n = regread ? NB_W'(3) : NB_W'(6);
        end
      end
      C_WRITE: begin
        if (pwd_en) begin
          fr_n = {1'b1, page, pwd, 1'b0, data, blk[2:0]};
          nb_n = NB_W'(70);
        end else begin
          fr_n = FW'({1'b1, page, 1'b0, data, blk[2:0]}) << (FW - 38);
          nb_n = NB_W'(38);
        end
      end
      default: begin
        fr_n = FW'({2'b10, pwd}) << (FW - 34);
        nb_n = NB_W'(34);
      end
    endcase
  end

  assign busy     = (st != S_IDLE) && (st != S_HOLD);
  assign hold     = (st == S_HOLD);
  assign capture  = (st == S_CAPT);
  assign field_on = (st == S_ON) || (st == S_RGAP) || (st == S_CAPT) || (st == S_PROG) || hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      cnt  <= '0;
      fr   <= '0;
      left <= '0;
      kind <= C_RST;
      capn <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy && start) begin
        st   <= S_START;
        cnt  <= CNT_W'(START_US);
        fr   <= fr_n;
        left <= nb_n;
        kind <= cmd;
        capn <= cap_len;
      end else if (hold && stop) begin
        st <= S_IDLE;
      end else if (busy && us_tick) begin
        if (cnt > CNT_W'(1)) begin
          cnt <= cnt - CNT_W'(1);
        end else begin
          case (st)
            S_START: begin
              st  <= S_ON;
              cnt <= fr[FW-1] ? CNT_W'(ONE_US) : CNT_W'(ZERO_US);
            end
            S_ON: begin
              st  <= S_GAP;
              cnt <= CNT_W'(GAP_US);
            end
            S_GAP: begin
              if (left == NB_W'(1)) begin
                case (kind)
                  C_WRITE: begin
                    st  <= S_PROG;
                    cnt <= CNT_W'(PROG_US);
                  end
                  C_WAKE: begin
                    st   <= S_HOLD;
                    done <= 1'b1;
                  end
                  default: begin
                    st  <= S_RGAP;
                    cnt <= CNT_W'(RGAP_US);
                  end
                endcase
              end else begin
                fr   <= fr << 1;
                left <= left - NB_W'(1);
                st   <= S_ON;
                cnt  <= fr[FW-2] ? CNT_W'(ONE_US) : CNT_W'(ZERO_US);
              end
            end
            S_RGAP: begin
              if (capn == 16'd0) begin
                st   <= S_IDLE;
                done <= 1'b1;
              end else begin
                st  <= S_CAPT;
                cnt <= CNT_W'(capn);
              end
            end
            default: begin
              st   <= S_IDLE;
              done <= 1'b1;
            end
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/tag_downlink_seq_chk.sv
module tag_downlink_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic us_tick,
  input logic start,
  input logic stop,
  input logic field_on,
  input logic capture,
  input logic busy,
  input logic done,
  input logic hold
);
  p_start_gap_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !field_on);

  p_stop_ends_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hold && stop && !start |=> !field_on && !busy);

  p_capture_with_field_r8: assert property (@(posedge clk) disable iff (!rst_n)
    capture |-> field_on);

  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_not_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !hold |-> !field_on && !capture);

  p_tick_gates_r12: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !us_tick |=> busy && $stable(field_on) && $stable(capture));
endmodule

bind tag_downlink_seq tag_downlink_seq_chk u_chk (.*);

// File: tb/sim_tag_downlink_seq.sv
module sim_tag_downlink_seq;
  localparam int PROG = 3000;

  typedef struct packed {
    logic [1:0]  cmd;
    logic        page;
    logic        pen;
    logic [31:0] pwd;
    logic [31:0] data;
    logic [7:0]  blk;
    logic [15:0] cap;
    logic [15:0] tail;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{2'd0, 1'b0, 1'b0, 32'h0,         32'h0,         8'h00, 16'd50, 16'd170},
    '{2'd1, 1'b0, 1'b0, 32'h0,         32'h0,         8'h05, 16'd30, 16'd150},
    '{2'd1, 1'b1, 1'b1, 32'hA5C30F96,  32'h0,         8'hFF, 16'd0,  16'd120},
    '{2'd2, 1'b0, 1'b0, 32'h0,         32'h80000001,  8'h03, 16'd0,  16'd3000},
    '{2'd2, 1'b1, 1'b1, 32'h12345678,  32'hFEDCBA98,  8'h06, 16'd0,  16'd3000},
    '{2'd3, 1'b1, 1'b0, 32'hC001D00D,  32'h0,         8'h00, 16'd0,  16'd0}
  };

  logic clk = 0, rst_n = 0, us_tick = 0, start = 0, stop = 0;
  logic [1:0] cmd = 0;
  logic page = 0, pwd_en = 0;
  logic [31:0] pwd = 0, data = 0;
  logic [7:0] blk = 0;
  logic [15:0] cap_len = 0;
  logic field_on, capture, busy, done;

  int checks = 0, fails = 0;
  bit fin = 0;
  int tdiv = 1, tcnt = 0;
  bit tick_en = 1;

  int run, nb, first_off, gap_bad, others, tail_len, cap_cnt, done_cnt;
  bit prev, seen_rise, mon_en;
  logic [69:0] gb;

  always #10 clk = ~clk;

  tag_downlink_seq #(.PROG_US(PROG)) u0 (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .start(start), .cmd(cmd),
    .page(page), .pwd_en(pwd_en), .pwd(pwd), .data(data), .blk(blk),
    .cap_len(cap_len), .stop(stop), .field_on(field_on), .capture(capture),
    .busy(busy), .done(done));

  always @(negedge clk) begin
    tcnt = (tcnt + 1 >= tdiv) ? 0 : tcnt + 1;
    us_tick <= tick_en && (tcnt == 0);
  end

  always @(posedge clk) begin
    #2;
    if (mon_en) begin
      if (capture) cap_cnt++;
      if (done) done_cnt++;
      if (field_on != prev) begin
        if (prev) begin
          if (run == 144 || run == 432) begin
            if (nb < 70) gb[69-nb] = (run == 432);
            nb++;
          end else begin
            tail_len = run;
            others++;
          end
        end else begin
          if (!seen_rise) first_off = run;
          else if (run != 160) gap_bad++;
          seen_rise = 1;
        end
        run = 1;
      end else run++;
      prev = field_on;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint got, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  function automatic void build(input vec_t v, output logic [69:0] f, output int n);
    f = '0;
    n = 2;
    if (v.cmd != 2'd0) begin
      f[69] = 1'b1;
      f[68] = (v.cmd == 2'd3) ? 1'b0 : v.page;
      if (v.pen || v.cmd == 2'd3)
        for (int i = 31; i >= 0; i--) begin f[69-n] = v.pwd[i]; n++; end
      if (v.cmd != 2'd3) begin f[69-n] = 1'b0; n++; end
      if (v.cmd == 2'd2)
        for (int i = 31; i >= 0; i--) begin f[69-n] = v.data[i]; n++; end
      if (v.cmd == 2'd2 || (v.cmd == 2'd1 && v.blk != 8'hFF))
        for (int i = 2; i >= 0; i--) begin f[69-n] = v.blk[i]; n++; end
    end
  endfunction

  function automatic string tagfor(input logic [1:0] c);
    case (c)
      2'd0: return "R3";
      2'd1: return "R6";
      2'd2: return "R4";
      default: return "R7";
    endcase
  endfunction

  task automatic launch(input vec_t v);
    @(negedge clk);
    cmd = v.cmd; page = v.page; pwd_en = v.pen; pwd = v.pwd; data = v.data;
    blk = v.blk; cap_len = v.cap;
    run = 0; nb = 0; first_off = -1; gap_bad = 0; others = 0; tail_len = -1;
    cap_cnt = 0; done_cnt = 0; prev = 0; seen_rise = 0; gb = '0; mon_en = 1;
    start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_done;
    for (int i = 0; i < 60000 && done_cnt == 0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_chk(input vec_t v);
    logic [69:0] ef;
    int en;
    build(v, ef, en);
    chk(nb == en, tagfor(v.cmd), nb, en);
    chk(gb == ef, tagfor(v.cmd), gb, ef);
    chk(first_off == 400, "R1", first_off, 400);
    chk(gap_bad == 0, "R2", gap_bad, 0);
    chk(done_cnt == 1, "R10", done_cnt, 1);
    if (v.cmd == 2'd3) begin
      chk(others == 0 && field_on, "R7", field_on, 1);
    end else begin
      chk(others == 1, "R2", others, 1);
      chk(tail_len == int'(v.tail), (v.cmd == 2'd2) ? "R5" : "R8", tail_len, v.tail);
      chk(cap_cnt == int'(v.cap), "R8", cap_cnt, v.cap);
      chk(!field_on && !busy && !capture, "R11", {field_on, busy, capture}, 0);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!fin) begin
      checks++;
      fails++;
      $display("FAIL watchdog got hung expected done");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!field_on && !busy && !done && !capture, "R11", {field_on, busy, done, capture}, 0);

    for (int k = 0; k < 6; k++) begin
      launch(VECS[k]);
      wait_done();
      finish_chk(VECS[k]);
      if (VECS[k].cmd == 2'd3) begin
        repeat (50) @(negedge clk);
        chk(field_on === 1'b1, "R7", field_on, 1);
        stop = 1;
        @(negedge clk);
        stop = 0;
        chk(!field_on && !busy, "R7", field_on, 0);
      end
      mon_en = 0;
    end

    begin
      vec_t v;
      v = '{2'd1, 1'b1, 1'b0, 32'h0, 32'h0, 8'h02, 16'd5, 16'd125};
      launch(v);
      repeat (500) @(negedge clk);
      cmd = 2'd2; data = 32'hFFFFFFFF; start = 1;
      @(negedge clk);
      start = 0;
      cmd = v.cmd; data = v.data;
      wait_done();
      chk(nb == 6, "R9", nb, 6);
      finish_chk(v);
      mon_en = 0;
    end

    begin
      vec_t v;
      v = '{2'd0, 1'b0, 1'b0, 32'h0, 32'h0, 8'h00, 16'd10, 16'd130};
      tick_en = 0;
      launch(v);
      repeat (1000) @(negedge clk);
      chk(busy && !field_on, "R12", {busy, field_on}, 2);
      mon_en = 0;
      tick_en = 1;
      wait_done();
      tdiv = 3;
      launch(v);
      wait_done();
      chk(first_off >= 1197 && first_off <= 1203, "R12", first_off, 1200);
      chk(done_cnt == 1 && !field_on, "R12", done_cnt, 1);
      mon_en = 0;
    end

    fin = 1;
    summary();
    $finish;
  end
endmodule